// File: doc/BRIEF.md
# Cascadable 8-bit Reload Timer

This block is a down-counting timer with a reload register. Software loads a start value n. While the timer runs, each event from the selected count source lowers the counter by one. When the counter stands at zero and one more event arrives, the timer underflows. On that underflow it reloads n from the reload register, raises a sticky request flag, emits a one-cycle underflow pulse and flips a toggle bit. The counter then keeps running.

Four count sources are available:
- a prescaler tick;
- the underflow pulse of a neighbouring timer, so timers can be cascaded;
- an external pin input, which is synchronised and counted on its rising edge only;
- the underflow pulse of a watchdog counter.

The toggle bit runs at half the underflow rate. It can be gated onto a pin output. Software reads the counter through a readback port, and the value is meaningful only while the timer is stopped. Software polls the request flag with a test strobe that clears it.

Top module: `reload_timer8`

## Requirements
- R1: After reset the counter, reload value, flag and toggle output are all 0, the timer is stopped (`rd_valid` = 1) and the source select is 0.
- R2: While running, each clock cycle in which the selected source is high and the counter is nonzero lowers the counter by one at the next clock edge.
- R3: A counter loaded with n underflows on the (n+1)-th selected source event. In the cycle of that event `uf_pulse` is high, and at the following edge the counter takes the reload value.
- R4: An underflow sets `flag` to 1. A `flag_test` strobe clears it at the next edge. If an underflow and a strobe fall in the same cycle, the flag stays set.
- R5: Control write: `ctl_wdata[0]` is run, `ctl_wdata[2:1]` selects the source (0 = prescaler, 1 = neighbour underflow, 2 = external pin, 3 = watchdog underflow) and `ctl_wdata[3]` enables the pin output. Sources that are not selected have no effect on the counter.
- R6: The external pin passes through two synchroniser flops. Only a rising edge counts, and it decrements the counter at the third clock edge after the pin rises. A pin held high counts once.
- R7: With run = 0 the counter holds its value whatever the sources do.
- R8: `tog_out` inverts on every underflow and at no other time. `pin_out` equals `tog_out` when the pin enable bit is 1 and is 0 otherwise.
- R9: `rd_count` shows the counter value. `rd_valid` is high exactly when run = 0.
- R10: A `wr_reload` in the same cycle as an underflow does not change the value reloaded by that underflow. The new value is used at the next underflow.
- R11: `wr_count` loads both the counter and the reload value. It overrides counting in that cycle, and no underflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_count | input | 1 | Write `wr_data` to counter and reload register |
| wr_reload | input | 1 | Write `wr_data` to reload register only |
| wr_data | input | 8 | Write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: [3] pin enable, [2:1] source, [0] run |
| src_prescale | input | 1 | Prescaler tick |
| src_chain | input | 1 | Neighbouring timer underflow |
| src_ext | input | 1 | External count pin (asynchronous) |
| src_wdt | input | 1 | Watchdog underflow |
| flag_test | input | 1 | Test-and-clear strobe for the flag |
| rd_count | output | 8 | Counter readback |
| rd_valid | output | 1 | Readback valid (timer stopped) |
| flag | output | 1 | Sticky underflow request flag |
| uf_pulse | output | 1 | Underflow event, same cycle as the counting event |
| tog_out | output | 1 | Underflow toggle (underflow rate / 2) |
| pin_out | output | 1 | Toggle gated by pin enable |

## Verification
Writes, control changes, counts and flag updates all appear one clock edge after the input cycle. `uf_pulse` is combinational in the input cycle, and an external pin rise reaches the counter at the third edge. The bench drives inputs on the falling edge and checks `uf_pulse` 1 ns later, inside the same cycle. It checks registered outputs 2 ns after each rising edge against a reference model that advances once per rising edge. The directed cases count ticks to the first underflow, wait exactly three edges for the pin, and place a reload write on the underflow cycle.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    SRC_PRESCALE = 2'd0,
    SRC_CHAIN    = 2'd1,
    SRC_EXTPIN   = 2'd2,
    SRC_WATCHDOG = 2'd3
  } src_e;

  // bit 3 pin enable, bits 2:1 source, bit 0 run
  typedef struct packed {
    logic pin_en;
    src_e src;
    logic run;
  } ctl_t;
endpackage

// File: rtl/rtmr_src_sel.sv
module rtmr_src_sel
  import rtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e sel,
  input  logic pre_tick,
  input  logic chain_uf,
  input  logic ext_pin,
  input  logic wdt_uf,
  output logic tick,
  output logic ext_rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], ext_pin};
  end

  // rising edge seen after the synchroniser stages
  assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  always_comb begin
    case (sel)
      SRC_PRESCALE: tick = pre_tick;
      SRC_CHAIN:    tick = chain_uf;
      SRC_EXTPIN:   tick = ext_rise;
      default:      tick = wdt_uf;
    endcase
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R6
endmodule

// File: rtl/rtmr_core.sv
module rtmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic [W-1:0] wr_data,
  input  logic         flag_test,
  output logic [W-1:0] cnt,
  output logic         uf,
  output logic         flag
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] rld_q;
  logic         step;

  function automatic logic [W-1:0] dec_one(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign step = run & tick & ~wr_count;
  assign uf   = step & (cnt == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= ZERO;
    else if (wr_count) cnt <= wr_data;
    else if (uf)       cnt <= rld_q;
    else if (step)     cnt <= dec_one(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rld_q <= ZERO;
    else if (wr_count || wr_reload) rld_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (uf)        flag <= 1'b1;
    else if (flag_test) flag <= 1'b0;
  end

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != ZERO) |=> cnt == dec_one($past(cnt))); // R2
  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt == $past(rld_q)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> flag); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> $stable(cnt)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> cnt == $past(wr_data)); // R11
endmodule

// File: rtl/rtmr_toggle.sv
module rtmr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic pin_en,
  output logic tog,
  output logic pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tog <= 1'b0;
    else if (uf) tog <= ~tog;
  end

  assign pin = tog & pin_en;

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> tog != $past(tog)); // R8
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uf |=> $stable(tog)); // R8
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rtmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [W-1:0]     wr_data,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             src_prescale,
  input  logic             src_chain,
  input  logic             src_ext,
  input  logic             src_wdt,
  input  logic             flag_test,
  output logic [W-1:0]     rd_count,
  output logic             rd_valid,
  output logic             flag,
  output logic             uf_pulse,
  output logic             tog_out,
  output logic             pin_out
);
  ctl_t ctl_q;
  logic sel_tick;
  logic ext_rise;
  logic uf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  rtmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .sel(ctl_q.src),
    .pre_tick(src_prescale), .chain_uf(src_chain),
    .ext_pin(src_ext), .wdt_uf(src_wdt),
    .tick(sel_tick), .ext_rise(ext_rise)
  );

  rtmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .tick(sel_tick),
    .wr_count(wr_count), .wr_reload(wr_reload), .wr_data(wr_data),
    .flag_test(flag_test), .cnt(rd_count), .uf(uf_evt), .flag(flag)
  );

  rtmr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .uf(uf_evt), .pin_en(ctl_q.pin_en),
    .tog(tog_out), .pin(pin_out)
  );

  assign uf_pulse = uf_evt;
  assign rd_valid = ~ctl_q.run;

  AST_NO_UF_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.run |-> !uf_evt); // R7
  AST_NO_UF_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |-> !uf_evt); // R11
endmodule

// File: tb/reload_timer8_tb.sv
module reload_timer8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_count = 0, wr_reload = 0, ctl_we = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] ctl_wdata = 0;
  logic       src_prescale = 0, src_chain = 0, src_ext = 0, src_wdt = 0, flag_test = 0;
  logic [7:0] rd_count;
  logic       rd_valid, flag, uf_pulse, tog_out, pin_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_cnt, m_rld;
  logic       m_flag, m_tog, m_run, m_pen;
  logic [1:0] m_src;
  logic       m_s1, m_s2, m_s3;

  reload_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .wr_reload(wr_reload),
    .wr_data(wr_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .src_prescale(src_prescale), .src_chain(src_chain), .src_ext(src_ext),
    .src_wdt(src_wdt), .flag_test(flag_test), .rd_count(rd_count),
    .rd_valid(rd_valid), .flag(flag), .uf_pulse(uf_pulse),
    .tog_out(tog_out), .pin_out(pin_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_tick();
    case (m_src)
      2'd0: return src_prescale;
      2'd1: return src_chain;
      2'd2: return m_s2 & ~m_s3;
      default: return src_wdt;
    endcase
  endfunction

  function automatic logic model_uf();
    return m_run && model_tick() && !wr_count && (m_cnt == 8'd0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_flag = 0; m_tog = 0; m_run = 0; m_pen = 0;
      m_src = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic u, t;
      t = model_tick();
      u = model_uf();
      if (wr_count) m_cnt = wr_data;
      else if (u) m_cnt = m_rld;
      else if (m_run && t) m_cnt = m_cnt - 8'd1;
      if (wr_count || wr_reload) m_rld = wr_data;
      if (u) m_flag = 1'b1;
      else if (flag_test) m_flag = 1'b0;
      if (u) m_tog = ~m_tog;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_ext;
      if (ctl_we) begin
        m_run = ctl_wdata[0]; m_src = ctl_wdata[2:1]; m_pen = ctl_wdata[3];
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("R2 model count", rd_count, m_cnt);
      chk("R4 model flag", flag, m_flag);
      chk("R8 model toggle", tog_out, m_tog);
      chk("R8 model pin", pin_out, m_tog & m_pen);
      chk("R9 model valid", rd_valid, !m_run);
    end
  end

  task automatic idle();
    wr_count = 0; wr_reload = 0; ctl_we = 0; flag_test = 0;
    src_prescale = 0; src_chain = 0; src_wdt = 0;
  endtask

  // inputs already set on a falling edge; check uf in-cycle, go to next falling edge
  task automatic step();
    #1;
    if (rst_n) chk("R3 uf_pulse", uf_pulse, model_uf());
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    idle(); wr_count = 1; wr_data = v; step(); idle();
  endtask

  task automatic setctl(input logic [3:0] v);
    idle(); ctl_we = 1; ctl_wdata = v; step(); idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int k;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", rd_count, 0);
    chk("R1 flag", flag, 0);
    chk("R1 toggle", tog_out, 0);
    chk("R1 valid", rd_valid, 1);
    rst_n = 1;
    @(negedge clk);

    // R3: n=5 needs 6 ticks
    load(8'd5);
    setctl(4'b0001);
    src_prescale = 1;
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      #1;
      if (uf_pulse) begin k = i; break; end
      @(negedge clk);
    end
    chk("R3 ticks to underflow", k, 6);
    @(negedge clk);
    idle();
    chk("R3 reload after underflow", rd_count, 5);
    chk("R4 flag set", flag, 1);
    chk("R8 toggle flipped", tog_out, 1);
    // R4 clear
    flag_test = 1; step(); idle();
    chk("R4 flag cleared", flag, 0);

    // R10: reload write on the underflow cycle
    load(8'd2);
    src_prescale = 1; step(); step();
    chk("R2 reached zero", rd_count, 0);
    wr_reload = 1; wr_data = 8'd9; step(); wr_reload = 0;
    chk("R10 old reload used", rd_count, 2);
    step(); step(); step();
    chk("R10 new reload used", rd_count, 9);
    idle();

    // R7 stop holds
    setctl(4'b0000);
    src_prescale = 1; src_chain = 1; src_wdt = 1;
    repeat (4) step();
    idle();
    chk("R7 held while stopped", rd_count, 9);
    chk("R9 valid while stopped", rd_valid, 1);

    // R5: watchdog selected, others ignored
    setctl(4'b0111);
    src_prescale = 1; src_chain = 1; step(); step(); idle();
    chk("R5 unselected ignored", rd_count, 9);
    src_wdt = 1; step(); idle();
    chk("R5 watchdog counts", rd_count, 8);

    // R6: external pin latency and edge-only
    setctl(4'b0101);
    load(8'd3);
    src_ext = 1; step();
    chk("R6 edge 1", rd_count, 3);
    step();
    chk("R6 edge 2", rd_count, 3);
    step();
    chk("R6 edge 3", rd_count, 2);
    repeat (5) step();
    chk("R6 held high counts once", rd_count, 2);
    src_ext = 0; repeat (3) step();

    // R11: load overrides counting at zero
    setctl(4'b1001);
    load(8'd0);
    src_prescale = 1; wr_count = 1; wr_data = 8'd7;
    #1; chk("R11 no uf on load", uf_pulse, 0);
    @(negedge clk); idle();
    chk("R11 load value", rd_count, 7);

    // R8 pin enable under random traffic
    for (int c = 0; c < 4000; c++) begin
      wr_count     = ($urandom % 64) == 0;
      wr_reload    = ($urandom % 24) == 0;
      wr_data      = 8'($urandom % 6);
      ctl_we       = ($urandom % 80) == 0;
      ctl_wdata    = 4'($urandom) | 4'b0001;
      src_prescale = $urandom % 2;
      src_chain    = ($urandom % 3) == 0;
      src_wdt      = ($urandom % 4) == 0;
      flag_test    = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) src_ext = ~src_ext;
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule